// File: doc/BRIEF.md
# Three-Wire Divider Word Loader

This block receives divider settings for a dual-modulus frequency synthesizer over a three-wire serial link: a data line, a bit clock and a load strobe. All three wires are brought into the system clock domain through synchronizer chains. A rising edge of the bit clock shifts one data bit into a 19-bit shift register, most significant bit first. A rising edge of the load strobe copies the register into one of two holding latches.

The bit shifted in last (bit 0) is the steering bit. When it is 1 the word goes to the reference latch, which holds a 14-bit reference divide ratio and a prescaler-select bit. When it is 0 the word goes to the program latch, which holds a 7-bit swallow count and an 11-bit main count. Each latch raises a one-cycle update strobe when it is written, so downstream counters can reload at their next period boundary. A word whose reference ratio or main count is below 3 is still latched, but it sets a sticky flag that only reset clears.

Top module: `serial_synth_loader`

## Requirements
- R1: While `rst_n` is low and after it rises, the outputs read ref_div=3, pre_sel=0, swal=0, main=3, both update strobes 0 and bad_val 0.
- R2: Each rising edge of `ser_clk_i` shifts one bit of `ser_dat_i` into bit 0 of a 19-bit register, so the 19 most recent bits count and older ones drop out. A bit clock held high shifts only once.
- R3: On a rising edge of `ser_load_i` with register bit 0 = 1, ref_div takes bits 14..1 and pre_sel takes bit 15. swal and main are unchanged.
- R4: On a rising edge of `ser_load_i` with register bit 0 = 0, swal takes bits 7..1 and main takes bits 18..8. ref_div and pre_sel are unchanged.
- R5: Each load raises exactly one update strobe for one system clock cycle: `ref_upd_o` for the reference latch, `prog_upd_o` for the program latch. The two strobes are never high together.
- R6: A load strobe held high writes once. A load that arrives while the bit clock is still high completes without the bit clock returning low.
- R7: When bit-clock and load rising edges are detected in the same cycle, the latch takes the register contents from before that cycle's shift.
- R8: A word with ref_div < 3 (steering bit 1) or main < 3 (steering bit 0) is latched as given and sets `bad_val_o`. The flag stays set through later legal words until reset. Legal words do not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_dat_i | input | 1 | Serial data line (asynchronous) |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous, sampled) |
| ser_load_i | input | 1 | Load strobe (asynchronous, sampled) |
| ref_div_o | output | 14 | Latched reference divide ratio |
| pre_sel_o | output | 1 | Latched prescaler select |
| swal_o | output | 7 | Latched swallow count |
| main_o | output | 11 | Latched main count |
| ref_upd_o | output | 1 | One-cycle pulse on reference latch write |
| prog_upd_o | output | 1 | One-cycle pulse on program latch write |
| bad_val_o | output | 1 | Sticky flag for a word below the legal minimum |

## Verification
A shift and a load can fall in the same system clock cycle when the bit clock and the load strobe rise together. The bench provokes this by shifting a full program word and then raising both wires at the same instant, with a 1 on the data line. The result is judged by reading the swallow and main outputs: they must equal the word shifted before, not the word moved one place by the extra bit. A related case raises the load while the bit clock is still high from the final bit.

// File: rtl/synth_load_pkg.sv
// Package: default geometry of the serial divider word and a range helper.
// Assumes: the word is sent most significant bit first, with the steering bit last.
package synth_load_pkg;
    localparam int unsigned DEF_SR_W   = 19;  // shift register length
    localparam int unsigned DEF_R_W    = 14;  // reference ratio width
    localparam int unsigned DEF_A_W    = 7;   // swallow count width
    localparam int unsigned DEF_B_W    = 11;  // main count width
    localparam int unsigned DEF_MIN_R  = 3;   // smallest legal reference ratio
    localparam int unsigned DEF_MIN_B  = 3;   // smallest legal main count
    localparam int unsigned DEF_STAGES = 2;   // synchronizer depth

    // True when a field value sits below its legal minimum.
    function automatic logic below_min(input int unsigned val, input int unsigned lim);
        return val < lim;
    endfunction
endpackage

// File: rtl/sync_chain.sv
// Module: multi-flop synchronizer for a bundle of asynchronous inputs.
// Assumes: STAGES >= 2; all bits take the same latency, so bits that change
// together stay aligned.
module sync_chain #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the sampled inputs through the chain of flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/edge_rise.sv
// Module: rising-edge detector on synchronized levels.
// Assumes: inputs are already in the clk domain; a pulse lasts one cycle.
module edge_rise #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev;

    // Remember the previous level of each input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;

    // R6: a level that stays high yields a single pulse
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/shift_capture.sv
// Module: serial shift register, filled one bit per detected bit-clock edge.
// Assumes: din is synchronized with the same latency as the edge pulse.
module shift_capture #(
    parameter int unsigned SR_W = 19
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            din,
    output logic [SR_W-1:0] word
);
    // Push the new bit into bit 0; the oldest bit falls off the top.
    always_ff @(posedge clk) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[SR_W-2:0], din};
    end

    // R2
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word[0] == $past(din)) && (word[SR_W-1:1] == $past(word[SR_W-2:0])));

    // R2
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word));
endmodule

// File: rtl/word_latch.sv
// Module: steers a shifted word into the reference or program latch,
// pulses the matching update strobe and keeps the sticky out-of-range flag.
// Assumes: load is a one-cycle pulse; word is the register before any
// shift that happens in the same cycle.
module word_latch
    import synth_load_pkg::*;
#(
    parameter int unsigned SR_W  = DEF_SR_W,
    parameter int unsigned R_W   = DEF_R_W,
    parameter int unsigned A_W   = DEF_A_W,
    parameter int unsigned B_W   = DEF_B_W,
    parameter int unsigned MIN_R = DEF_MIN_R,
    parameter int unsigned MIN_B = DEF_MIN_B
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [SR_W-1:0] word,
    output logic [R_W-1:0]  ref_div,
    output logic            pre_sel,
    output logic [A_W-1:0]  swal,
    output logic [B_W-1:0]  main,
    output logic            ref_upd,
    output logic            prog_upd,
    output logic            bad_val
);
    localparam int unsigned PRE_POS = R_W + 1;
    localparam int unsigned B_LSB   = A_W + 1;

    logic           to_ref;
    logic [R_W-1:0] new_r;
    logic [A_W-1:0] new_a;
    logic [B_W-1:0] new_b;
    logic           new_bad;

    // Pull the fields out of the word and judge their range.
    always_comb begin
        to_ref  = word[0];
        new_r   = word[R_W:1];
        new_a   = word[A_W:1];
        new_b   = word[B_LSB +: B_W];
        new_bad = to_ref ? below_min(32'(new_r), MIN_R) : below_min(32'(new_b), MIN_B);
    end

    // Reference latch with its update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_div <= R_W'(MIN_R);
            pre_sel <= 1'b0;
            ref_upd <= 1'b0;
        end else begin
            ref_upd <= load && to_ref;
            if (load && to_ref) begin
                ref_div <= new_r;
                pre_sel <= word[PRE_POS];
            end
        end
    end

    // Program latch with its update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swal     <= '0;
            main     <= B_W'(MIN_B);
            prog_upd <= 1'b0;
        end else begin
            prog_upd <= load && !to_ref;
            if (load && !to_ref) begin
                swal <= new_a;
                main <= new_b;
            end
        end
    end

    // Sticky flag for a latched word below the legal minimum.
    always_ff @(posedge clk) begin
        if (!rst_n)               bad_val <= 1'b0;
        else if (load && new_bad) bad_val <= 1'b1;
    end

    // R5
    ref_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_upd |=> !ref_upd);
    // R5
    prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_upd |=> !prog_upd);
    // R5
    upd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_upd && prog_upd));
    // R3
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_upd |-> ($stable(ref_div) && $stable(pre_sel)));
    // R4
    prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_upd |-> ($stable(swal) && $stable(main)));
    // R8
    bad_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_val |=> bad_val);
endmodule

// File: rtl/serial_synth_loader.sv
// Module: top of the three-wire divider word loader.
// Assumes: data, bit clock and load come from another domain and each holds
// its level for several system clock cycles; none of them clocks a flop.
module serial_synth_loader
    import synth_load_pkg::*;
#(
    parameter int unsigned SR_W   = DEF_SR_W,
    parameter int unsigned R_W    = DEF_R_W,
    parameter int unsigned A_W    = DEF_A_W,
    parameter int unsigned B_W    = DEF_B_W,
    parameter int unsigned MIN_R  = DEF_MIN_R,
    parameter int unsigned MIN_B  = DEF_MIN_B,
    parameter int unsigned STAGES = DEF_STAGES
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_dat_i,
    input  logic           ser_clk_i,
    input  logic           ser_load_i,
    output logic [R_W-1:0] ref_div_o,
    output logic           pre_sel_o,
    output logic [A_W-1:0] swal_o,
    output logic [B_W-1:0] main_o,
    output logic           ref_upd_o,
    output logic           prog_upd_o,
    output logic           bad_val_o
);
    localparam int unsigned N_WIRES = 3;

    logic [N_WIRES-1:0] wires_sync;
    logic [1:0]         edges;
    logic [SR_W-1:0]    sr_word;

    sync_chain #(.W(N_WIRES), .STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ser_load_i, ser_clk_i, ser_dat_i}),
        .dout (wires_sync)
    );

    edge_rise #(.W(2)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (wires_sync[2:1]),
        .rise (edges)
    );

    shift_capture #(.SR_W(SR_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(edges[0]),
        .din     (wires_sync[0]),
        .word    (sr_word)
    );

    word_latch #(
        .SR_W(SR_W), .R_W(R_W), .A_W(A_W), .B_W(B_W),
        .MIN_R(MIN_R), .MIN_B(MIN_B)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (edges[1]),
        .word    (sr_word),
        .ref_div (ref_div_o),
        .pre_sel (pre_sel_o),
        .swal    (swal_o),
        .main    (main_o),
        .ref_upd (ref_upd_o),
        .prog_upd(prog_upd_o),
        .bad_val (bad_val_o)
    );

    // R1
    rst_vals_chk: assert property (@(posedge clk)
        !rst_n |=> (ref_div_o == R_W'(MIN_R)) && (main_o == B_W'(MIN_B)) && (swal_o == '0)
                   && !pre_sel_o && !bad_val_o && !ref_upd_o && !prog_upd_o);
endmodule

// File: tb/serial_synth_loader_tb.sv
// Directed bench for the three-wire divider word loader.
module serial_synth_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_dat_i = 1'b0;
    logic        ser_clk_i = 1'b0;
    logic        ser_load_i = 1'b0;
    logic [13:0] ref_div_o;
    logic        pre_sel_o;
    logic [6:0]  swal_o;
    logic [10:0] main_o;
    logic        ref_upd_o;
    logic        prog_upd_o;
    logic        bad_val_o;

    int checks = 0;
    int failures = 0;
    int n_ref = 0;
    int n_prog = 0;

    always #2.5 clk = ~clk;

    serial_synth_loader u_dut (
        .clk(clk), .rst_n(rst_n),
        .ser_dat_i(ser_dat_i), .ser_clk_i(ser_clk_i), .ser_load_i(ser_load_i),
        .ref_div_o(ref_div_o), .pre_sel_o(pre_sel_o), .swal_o(swal_o), .main_o(main_o),
        .ref_upd_o(ref_upd_o), .prog_upd_o(prog_upd_o), .bad_val_o(bad_val_o)
    );

    // Count strobe cycles away from the active edge.
    always @(negedge clk) begin
        if (ref_upd_o)  n_ref++;
        if (prog_upd_o) n_prog++;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [18:0] mk_ref(input int r, input bit pre);
        return {3'b000, pre, 14'(r), 1'b1};
    endfunction

    function automatic logic [18:0] mk_prog(input int a, input int b);
        return {11'(b), 7'(a), 1'b0};
    endfunction

    task automatic send_bit(input bit b);
        ser_dat_i = b; idle(4);
        ser_clk_i = 1'b1; idle(4);
        ser_clk_i = 1'b0; idle(4);
    endtask

    task automatic send_word(input logic [18:0] w);
        for (int i = 18; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pulse_load();
        ser_load_i = 1'b1; idle(8);
        ser_load_i = 1'b0; idle(8);
    endtask

    task automatic do_reset();
        ser_dat_i = 0; ser_clk_i = 0; ser_load_i = 0;
        rst_n = 1'b0; idle(5);
        rst_n = 1'b1; idle(3);
    endtask

    task automatic t_reset();
        idle(3);
        chk("R1", "ref_div in reset", int'(ref_div_o), 3);
        do_reset();
        chk("R1", "ref_div", int'(ref_div_o), 3);
        chk("R1", "pre_sel", int'(pre_sel_o), 0);
        chk("R1", "swal", int'(swal_o), 0);
        chk("R1", "main", int'(main_o), 3);
        chk("R1", "bad_val", int'(bad_val_o), 0);
        chk("R1", "strobes", n_ref + n_prog, 0);
    endtask

    task automatic t_ref_word();
        int r0 = n_ref; int p0 = n_prog;
        send_word(mk_ref(16383, 1'b1)); pulse_load();
        chk("R3", "ref_div max", int'(ref_div_o), 16383);
        chk("R3", "pre_sel", int'(pre_sel_o), 1);
        chk("R3", "swal kept", int'(swal_o), 0);
        chk("R3", "main kept", int'(main_o), 3);
        chk("R5", "ref strobe count", n_ref - r0, 1);
        chk("R5", "prog strobe count", n_prog - p0, 0);
    endtask

    task automatic t_prog_word();
        int r0 = n_ref; int p0 = n_prog;
        send_word(mk_prog(85, 1234)); pulse_load();
        chk("R4", "swal", int'(swal_o), 85);
        chk("R4", "main", int'(main_o), 1234);
        chk("R4", "ref_div kept", int'(ref_div_o), 16383);
        chk("R4", "pre_sel kept", int'(pre_sel_o), 1);
        chk("R5", "prog strobe count", n_prog - p0, 1);
        chk("R5", "ref strobe count", n_ref - r0, 0);
        chk("R8", "legal words leave flag low", int'(bad_val_o), 0);
    endtask

    task automatic t_extra_bits();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        send_word(mk_prog(127, 3)); pulse_load();
        chk("R2", "swal after prefix", int'(swal_o), 127);
        chk("R2", "main after prefix", int'(main_o), 3);
    endtask

    task automatic t_held_levels();
        logic [18:0] w = mk_ref(12345, 1'b0);
        int r0 = n_ref;
        for (int i = 18; i >= 1; i--) send_bit(w[i]);
        ser_dat_i = w[0]; idle(4);
        ser_clk_i = 1'b1; idle(40);
        ser_load_i = 1'b1; idle(40);
        chk("R6", "ref_div with bit clock high", int'(ref_div_o), 12345);
        chk("R6", "pre_sel", int'(pre_sel_o), 0);
        chk("R6", "one strobe for held load", n_ref - r0, 1);
        ser_load_i = 1'b0; ser_clk_i = 1'b0; idle(8);
        chk("R2", "held bit clock shifted once", int'(ref_div_o), 12345);
    endtask

    task automatic t_same_cycle();
        send_word(mk_prog(5, 700));
        ser_dat_i = 1'b1; idle(4);
        ser_clk_i = 1'b1; ser_load_i = 1'b1; idle(8);
        ser_clk_i = 1'b0; ser_load_i = 1'b0; idle(8);
        chk("R7", "swal from pre-shift word", int'(swal_o), 5);
        chk("R7", "main from pre-shift word", int'(main_o), 700);
    endtask

    task automatic t_illegal();
        send_word(mk_ref(2, 1'b0)); pulse_load();
        chk("R8", "low ref_div latched", int'(ref_div_o), 2);
        chk("R8", "flag on low ref_div", int'(bad_val_o), 1);
        send_word(mk_ref(50, 1'b0)); pulse_load();
        chk("R8", "legal ref_div latched", int'(ref_div_o), 50);
        chk("R8", "flag sticky", int'(bad_val_o), 1);
        do_reset();
        chk("R8", "flag cleared by reset", int'(bad_val_o), 0);
        chk("R1", "ref_div after reset", int'(ref_div_o), 3);
        send_word(mk_prog(1, 2)); pulse_load();
        chk("R8", "low main latched", int'(main_o), 2);
        chk("R8", "flag on low main", int'(bad_val_o), 1);
    endtask

    initial begin
        t_reset();
        t_ref_word();
        t_prog_word();
        t_extra_bits();
        t_held_levels();
        t_same_cycle();
        t_illegal();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule